// File: doc/BRIEF.md
# Stride-Locked Training Prefetcher

This block sits in front of a memory controller's read path and helps a training sequence produce a long, regular train of reads. Software programs a request limit and sets a training-mode bit. Setting that bit wipes any stride history and any lines held for earlier runs. The block then watches demand reads for a run of reads to successive 64-byte lines inside one 4 KB page. When the run reaches the configured length of two or three reads, the block takes over. It issues prefetch requests for the following lines on its own, one per cycle, until the programmed limit is used up or the page ends. It then drops the training-mode bit by itself.

Prefetch data returns from memory through a fill port and is kept, with its line tag and a valid flag, in a small line buffer. Demand reads that follow look up the buffer. A read that hits gets its line from the buffer one cycle later. A read that misses is passed on to memory unchanged. All addresses are cache-line addresses: the byte address divided by 64.

Top module: `stride_train_pf`

## Requirements
- R1: After reset the training-mode flag reads 0, and no prefetch request, hit response or forwarded read is asserted.
- R2: A register write with the training bit at 1 sets the training-mode flag at the next edge. The same write discards all stride history, so earlier reads never count toward a lock. It also invalidates every line held in the buffer, so a later read of such a line misses.
- R3: A lock happens only while training mode is on. It needs a run of reads to lines n, n+1, … inside one 4 KB page (line-address bits [5:0] are the offset within the page). The run must be 2 reads long when the three-read option is 0, and 3 reads long when it is 1. A gap in the line sequence restarts the run.
- R4: The first prefetch request is asserted in the cycle after the edge that samples the locking read. Requests then follow one per cycle, with line addresses that rise by one, starting at the locking line plus one.
- R5: The number of prefetches equals (limit + 1) minus the run length, or zero when that is not positive. The limit is the programmed field value.
- R6: Prefetches never leave the 4 KB page of the training reads. The line with offset 63 is the last one requested.
- R7: The training-mode flag clears itself at the edge that ends the last prefetch cycle. When no prefetch is due, it clears at the edge that samples the locking read.
- R8: A fill stores its line data under its line address. A later demand read of a stored line asserts the hit response one cycle later, carrying that data and no forwarded read.
- R9: A demand read that matches no stored line asserts the forwarded-read output one cycle later with the same line address, and no hit.
- R10: When a fill and a demand read of the same line arrive in the same cycle, the read sees the buffer as it was before the fill and is forwarded. A later read of that line hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_limit | input | LIM_W | Request-limit field (training run length minus one) |
| cfg_train | input | 1 | Training-mode bit written with the strobe |
| cfg_three | input | 1 | 1: lock needs three reads, 0: two reads |
| train_active | output | 1 | Current training-mode flag |
| rd_valid | input | 1 | Demand read valid |
| rd_line | input | ADDR_W | Demand read line address |
| pf_req_valid | output | 1 | Prefetch request valid |
| pf_req_line | output | ADDR_W | Prefetch request line address |
| fill_valid | input | 1 | Prefetch data return valid |
| fill_line | input | ADDR_W | Line address of returned data |
| fill_data | input | LINE_BYTES*8 | Returned line data |
| rsp_hit | output | 1 | Demand read served from the buffer |
| rsp_data | output | LINE_BYTES*8 | Line data for a hit |
| fwd_valid | output | 1 | Demand read passed on to memory |
| fwd_line | output | ADDR_W | Line address of the passed-on read |

## Verification
The buffer write from a fill and the buffer lookup of a demand read can land in the same cycle on the same line. The bench drives both in one cycle. It expects a forwarded read carrying that line and no hit, and then a hit with the filled data on the next read of the line. A second overlap is the training-bit write against stride history already in the table. The bench builds a two-read run with training off, then sets the bit and continues the run. It checks that no prefetch appears until a full new run has been seen.

// File: rtl/stride_train_pf_pkg.sv
package stride_train_pf_pkg;

   typedef enum logic {
      ENG_IDLE  = 1'b0,
      ENG_ISSUE = 1'b1
   } eng_state_e;

   // Run length that locks the detector.
   function automatic logic [1:0] lock_need(input logic three);
      return three ? 2'd3 : 2'd2;
   endfunction

endpackage

// File: rtl/stp_stride_table.sv
module stp_stride_table #(
   parameter int ADDR_W = 26,
   parameter int OFF_W  = 6,
   parameter int TBL_N  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              rd_valid,
   input  logic [ADDR_W-1:0] rd_line,
   input  logic [1:0]        need,
   output logic              reached
);
   localparam int PAGE_W = ADDR_W - OFF_W;
   localparam int IDX_W  = (TBL_N > 1) ? $clog2(TBL_N) : 1;

   logic              ent_vld  [TBL_N];
   logic [PAGE_W-1:0] ent_page [TBL_N];
   logic [OFF_W-1:0]  ent_last [TBL_N];
   logic [1:0]        ent_cnt  [TBL_N];
   logic [TBL_N-1:0]  hit_vec;
   logic              hit_any;
   logic [IDX_W-1:0]  hit_idx, rr_q, tgt;
   logic              seq;
   logic [1:0]        cnt_new;

   wire [PAGE_W-1:0] rd_page = rd_line[ADDR_W-1:OFF_W];
   wire [OFF_W-1:0]  rd_off  = rd_line[OFF_W-1:0];

   for (genvar i = 0; i < TBL_N; i++) begin : g_cmp
      assign hit_vec[i] = ent_vld[i] && (ent_page[i] == rd_page);
   end

   always_comb begin
      hit_any = 1'b0;
      hit_idx = '0;
      for (int i = TBL_N - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            hit_any = 1'b1;
            hit_idx = IDX_W'(i);
         end
      end
   end

   always_comb begin
      seq = hit_any &&
            (({1'b0, ent_last[hit_idx]} + (OFF_W+1)'(1)) == {1'b0, rd_off});
      if (!seq)                         cnt_new = 2'd1;
      else if (ent_cnt[hit_idx] == 2'd3) cnt_new = 2'd3;
      else                              cnt_new = ent_cnt[hit_idx] + 2'd1;
      tgt = hit_any ? hit_idx : rr_q;
   end

   assign reached = rd_valid && !flush && (cnt_new == need);

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         for (int i = 0; i < TBL_N; i++) begin
            ent_vld[i]  <= 1'b0;
            ent_page[i] <= '0;
            ent_last[i] <= '0;
            ent_cnt[i]  <= '0;
         end
         rr_q <= '0;
      end else if (rd_valid) begin
         ent_vld[tgt]  <= 1'b1;
         ent_page[tgt] <= rd_page;
         ent_last[tgt] <= rd_off;
         ent_cnt[tgt]  <= cnt_new;
         if (!hit_any)
            rr_q <= (rr_q == IDX_W'(TBL_N - 1)) ? '0 : rr_q + IDX_W'(1);
      end
   end

   // R3: one page never occupies two entries
   p_page_unique_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

endmodule

// File: rtl/stp_issue_engine.sv
module stp_issue_engine
   import stride_train_pf_pkg::*;
#(
   parameter int ADDR_W = 26,
   parameter int OFF_W  = 6,
   parameter int LIM_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_line,
   input  logic [LIM_W:0]    budget,
   output logic              busy,
   output logic              finish,
   output logic              req_valid,
   output logic [ADDR_W-1:0] req_line
);
   eng_state_e        st_q;
   logic [ADDR_W-1:0] nxt_q;
   logic [LIM_W:0]    left_q;
   logic [LIM_W:0]    issued_q, budget_q;
   logic              start_empty, last_issue;

   assign busy      = (st_q == ENG_ISSUE);
   assign req_valid = busy;
   assign req_line  = nxt_q;

   assign start_empty = (budget == '0) || (&start_line[OFF_W-1:0]);
   assign last_issue  = busy && ((left_q == (LIM_W+1)'(1)) || (&nxt_q[OFF_W-1:0]));
   assign finish      = !abort && ((start && !busy && start_empty) || last_issue);

   always_ff @(posedge clk) begin
      if (!rst_n || abort) begin
         st_q   <= ENG_IDLE;
         nxt_q  <= '0;
         left_q <= '0;
      end else if (start && !busy) begin
         if (!start_empty) begin
            st_q   <= ENG_ISSUE;
            nxt_q  <= start_line + ADDR_W'(1);
            left_q <= budget;
         end
      end else if (busy) begin
         nxt_q  <= nxt_q + ADDR_W'(1);
         left_q <= left_q - (LIM_W+1)'(1);
         if (last_issue) st_q <= ENG_IDLE;
      end
   end

   // Checker counter: requests issued since the last start.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issued_q <= '0;
         budget_q <= '0;
      end else if (start && !busy) begin
         issued_q <= '0;
         budget_q <= budget;
      end else if (req_valid) begin
         issued_q <= issued_q + (LIM_W+1)'(1);
      end
   end

   // R5: never more requests than the budget taken at lock
   p_budget_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (issued_q < budget_q));
   // R4: back-to-back requests walk up by one line
   p_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && $past(req_valid) && !$past(abort)) |-> (req_line == $past(req_line) + ADDR_W'(1)));
   // R6: the last line of a page ends the burst
   p_page_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (&req_line[OFF_W-1:0])) |=> !req_valid);

endmodule

// File: rtl/stp_line_buffer.sv
module stp_line_buffer #(
   parameter int ADDR_W = 26,
   parameter int LINE_W = 512,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              fill_valid,
   input  logic [ADDR_W-1:0] fill_line,
   input  logic [LINE_W-1:0] fill_data,
   input  logic              rd_valid,
   input  logic [ADDR_W-1:0] rd_line,
   output logic              rsp_hit,
   output logic [LINE_W-1:0] rsp_data,
   output logic              fwd_valid,
   output logic [ADDR_W-1:0] fwd_line
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic              slot_vld  [DEPTH];
   logic [ADDR_W-1:0] slot_tag  [DEPTH];
   logic [LINE_W-1:0] slot_data [DEPTH];
   logic [DEPTH-1:0]  match_rd, match_fill;
   logic [PTR_W-1:0]  wptr_q;
   logic [LINE_W-1:0] sel_data;
   logic              hit_any;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign match_rd[i]   = slot_vld[i] && (slot_tag[i] == rd_line);
      assign match_fill[i] = slot_vld[i] && (slot_tag[i] == fill_line);

      always_ff @(posedge clk) begin
         if (!rst_n || flush) begin
            slot_vld[i]  <= 1'b0;
            slot_tag[i]  <= '0;
            slot_data[i] <= '0;
         end else if (fill_valid && (wptr_q == PTR_W'(i))) begin
            slot_vld[i]  <= 1'b1;
            slot_tag[i]  <= fill_line;
            slot_data[i] <= fill_data;
         end else if (fill_valid && match_fill[i]) begin
            slot_vld[i]  <= 1'b0;   // older copy of a refilled line
         end
      end
   end

   always_comb begin
      sel_data = '0;
      for (int i = 0; i < DEPTH; i++)
         if (match_rd[i]) sel_data = sel_data | slot_data[i];
   end

   assign hit_any = |match_rd;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) wptr_q <= '0;
      else if (fill_valid)
         wptr_q <= (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + PTR_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_hit   <= 1'b0;
         rsp_data  <= '0;
         fwd_valid <= 1'b0;
         fwd_line  <= '0;
      end else begin
         rsp_hit   <= rd_valid && hit_any;
         fwd_valid <= rd_valid && !hit_any;
         if (rd_valid && hit_any)  rsp_data <= sel_data;
         if (rd_valid && !hit_any) fwd_line <= rd_line;
      end
   end

   // R8: a line is held in at most one slot
   p_one_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_rd));
   // R9: a read is either served or forwarded, never both
   p_hit_or_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_hit && fwd_valid));
   // R9: responses only follow a sampled read
   p_resp_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_hit || fwd_valid) |-> $past(rd_valid));

endmodule

// File: rtl/stride_train_pf.sv
module stride_train_pf
   import stride_train_pf_pkg::*;
#(
   parameter int ADDR_W     = 26,
   parameter int LINE_BYTES = 64,
   parameter int PAGE_BYTES = 4096,
   parameter int LIM_W      = 4,
   parameter int TBL_N      = 4,
   parameter int PF_DEPTH   = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [LIM_W-1:0]        cfg_limit,
   input  logic                    cfg_train,
   input  logic                    cfg_three,
   output logic                    train_active,
   input  logic                    rd_valid,
   input  logic [ADDR_W-1:0]       rd_line,
   output logic                    pf_req_valid,
   output logic [ADDR_W-1:0]       pf_req_line,
   input  logic                    fill_valid,
   input  logic [ADDR_W-1:0]       fill_line,
   input  logic [LINE_BYTES*8-1:0] fill_data,
   output logic                    rsp_hit,
   output logic [LINE_BYTES*8-1:0] rsp_data,
   output logic                    fwd_valid,
   output logic [ADDR_W-1:0]       fwd_line
);
   localparam int LINE_W = LINE_BYTES * 8;
   localparam int OFF_W  = $clog2(PAGE_BYTES / LINE_BYTES);

   if (PAGE_BYTES % LINE_BYTES != 0 || (1 << OFF_W) != PAGE_BYTES / LINE_BYTES) begin : g_bad_page
      $error("page size must be a power-of-two multiple of the line size");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("line address must be wider than the page offset");
   end
   if (LIM_W < 2) begin : g_bad_lim
      $error("limit field must hold a three-read run");
   end
   if (PF_DEPTH < (1 << LIM_W)) begin : g_bad_depth
      $error("buffer must hold the largest prefetch burst");
   end

   logic             train_q, three_q;
   logic [LIM_W-1:0] limit_q;
   logic             flush, reached, lock, busy, finish;
   logic [LIM_W:0]   total, need_ext, budget;

   assign flush  = cfg_we && cfg_train;
   assign total  = {1'b0, limit_q} + (LIM_W+1)'(1);
   assign need_ext = (LIM_W+1)'(lock_need(three_q));
   assign budget = (total > need_ext) ? (total - need_ext) : '0;
   assign lock   = reached && train_q && !busy && !cfg_we;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         train_q <= 1'b0;
         three_q <= 1'b0;
         limit_q <= '0;
      end else if (cfg_we) begin
         train_q <= cfg_train;
         three_q <= cfg_three;
         limit_q <= cfg_limit;
      end else if (finish) begin
         train_q <= 1'b0;
      end
   end

   assign train_active = train_q;

   stp_stride_table #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .TBL_N(TBL_N)) u_table (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .rd_valid(rd_valid), .rd_line(rd_line),
      .need(lock_need(three_q)), .reached(reached)
   );

   stp_issue_engine #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LIM_W(LIM_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .abort(cfg_we),
      .start(lock), .start_line(rd_line), .budget(budget),
      .busy(busy), .finish(finish),
      .req_valid(pf_req_valid), .req_line(pf_req_line)
   );

   stp_line_buffer #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .DEPTH(PF_DEPTH)) u_buf (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .fill_valid(fill_valid), .fill_line(fill_line), .fill_data(fill_data),
      .rd_valid(rd_valid), .rd_line(rd_line),
      .rsp_hit(rsp_hit), .rsp_data(rsp_data),
      .fwd_valid(fwd_valid), .fwd_line(fwd_line)
   );

   // R2: setting the bit turns training on with no burst in flight
   p_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_train) |=> (train_active && !pf_req_valid));
   // R3: prefetching happens only in training mode
   p_only_train_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pf_req_valid |-> train_active);
   // R4: a burst starts right after a sampled read
   p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pf_req_valid) |-> $past(rd_valid));
   // R7: the mode drops when a burst ends on its own
   p_self_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pf_req_valid) && !$past(cfg_we)) |-> !train_active);

endmodule

// File: tb/stride_train_pf_tb.sv
module stride_train_pf_tb;
   localparam int AW = 26;
   localparam int LW = 512;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0, cfg_train = 1'b0, cfg_three = 1'b0;
   logic [3:0]    cfg_limit = '0;
   logic          train_active;
   logic          rd_valid = 1'b0;
   logic [AW-1:0] rd_line = '0;
   logic          pf_req_valid;
   logic [AW-1:0] pf_req_line;
   logic          fill_valid = 1'b0;
   logic [AW-1:0] fill_line = '0;
   logic [LW-1:0] fill_data = '0;
   logic          rsp_hit, fwd_valid;
   logic [LW-1:0] rsp_data;
   logic [AW-1:0] fwd_line;

   int n_chk = 0, n_bad = 0;
   int log_total = 0;
   logic [AW-1:0] req_log [64];
   bit finished = 0;

   always #2.5 clk = ~clk;

   stride_train_pf u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_limit(cfg_limit),
      .cfg_train(cfg_train), .cfg_three(cfg_three), .train_active(train_active),
      .rd_valid(rd_valid), .rd_line(rd_line),
      .pf_req_valid(pf_req_valid), .pf_req_line(pf_req_line),
      .fill_valid(fill_valid), .fill_line(fill_line), .fill_data(fill_data),
      .rsp_hit(rsp_hit), .rsp_data(rsp_data),
      .fwd_valid(fwd_valid), .fwd_line(fwd_line)
   );

   // vectors: limit, three-read option, page, start offset, expected prefetches
   localparam int NV = 6;
   localparam int V_LIM  [NV] = '{7, 7, 15, 1, 2, 15};
   localparam int V_THR  [NV] = '{0, 1, 0, 0, 1, 1};
   localparam int V_PAGE [NV] = '{3, 4, 5, 6, 7, 8};
   localparam int V_OFF  [NV] = '{0, 0, 60, 10, 20, 8};
   localparam int V_EXP  [NV] = '{6, 5, 2, 0, 0, 13};

   function automatic logic [LW-1:0] pat(input logic [AW-1:0] a);
      return {16{ {6'h2A, a} ^ 32'h5A5A_0000 }};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // prefetch request logger, sampled mid-cycle
   always @(negedge clk) begin
      if (rst_n && pf_req_valid) begin
         req_log[log_total & 63] = pf_req_line;
         log_total++;
         chk(train_active == 1'b1, "R7 mode held while issuing", 64'(train_active), 64'd1);
      end
   end

   task automatic cfg_write(input int lim, input bit three, input bit train);
      @(negedge clk);
      cfg_we = 1'b1; cfg_limit = 4'(lim); cfg_three = three; cfg_train = train;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic h, output logic [LW-1:0] d,
                     output logic f, output logic [AW-1:0] fl);
      @(negedge clk);
      rd_valid = 1'b1; rd_line = a;
      @(negedge clk);
      h = rsp_hit; d = rsp_data; f = fwd_valid; fl = fwd_line;
      rd_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic h, f;
      logic [LW-1:0] d;
      logic [AW-1:0] fl, base_l;
      int base;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(train_active == 0, "R1 mode", 64'(train_active), 0);
      chk(pf_req_valid == 0, "R1 prefetch", 64'(pf_req_valid), 0);
      chk(rsp_hit == 0 && fwd_valid == 0, "R1 responses", 64'({rsp_hit, fwd_valid}), 0);

      // vector walk
      for (int v = 0; v < NV; v++) begin
         int need;
         need   = (V_THR[v] != 0) ? 3 : 2;
         base_l = AW'(V_PAGE[v] * 64 + V_OFF[v]);
         cfg_write(V_LIM[v], V_THR[v][0], 1'b1);
         chk(train_active == 1, "R2 mode set", 64'(train_active), 1);
         base = log_total;
         for (int k = 0; k < need; k++) rd(base_l + AW'(k), h, d, f, fl);
         if (V_EXP[v] == 0)
            chk(train_active == 0, "R7 clear at lock", 64'(train_active), 0);
         idle(20);
         chk(log_total - base == V_EXP[v], "R5 R6 prefetch count", 64'(log_total - base), 64'(V_EXP[v]));
         chk(train_active == 0, "R7 self clear", 64'(train_active), 0);
         for (int j = 0; j < V_EXP[v] && j < log_total - base; j++)
            chk(req_log[(base + j) & 63] == base_l + AW'(need + j), "R4 prefetch line",
                64'(req_log[(base + j) & 63]), 64'(base_l + AW'(need + j)));
         for (int j = 0; j < log_total - base; j++) begin
            @(negedge clk);
            fill_valid = 1'b1;
            fill_line  = req_log[(base + j) & 63];
            fill_data  = pat(fill_line);
         end
         @(negedge clk);
         fill_valid = 1'b0;
         for (int j = 0; j < V_EXP[v]; j++) begin
            rd(base_l + AW'(need + j), h, d, f, fl);
            chk(h == 1 && f == 0, "R8 hit", 64'({h, f}), 64'b10);
            chk(d == pat(base_l + AW'(need + j)), "R8 data", d[63:0], pat(base_l + AW'(need + j))[63:0]);
         end
         rd(base_l, h, d, f, fl);
         chk(h == 0 && f == 1 && fl == base_l, "R9 forward", 64'(fl), 64'(base_l));
      end

      // R3: no lock with training off
      base = log_total;
      base_l = AW'(11 * 64);
      for (int k = 0; k < 3; k++) rd(base_l + AW'(k), h, d, f, fl);
      idle(5);
      chk(log_total == base, "R3 no lock when off", 64'(log_total - base), 0);

      // R2: history flushed by setting the bit
      base_l = AW'(12 * 64);
      rd(base_l, h, d, f, fl);
      rd(base_l + 1, h, d, f, fl);
      cfg_write(4, 1'b1, 1'b1);
      base = log_total;
      rd(base_l + 2, h, d, f, fl);
      idle(3);
      chk(log_total == base && train_active == 1, "R2 history flushed", 64'(log_total - base), 0);
      rd(base_l + 3, h, d, f, fl);
      rd(base_l + 4, h, d, f, fl);
      idle(6);
      chk(log_total - base == 2, "R3 three-read lock count", 64'(log_total - base), 2);
      chk(req_log[base & 63] == base_l + 5, "R3 three-read lock line", 64'(req_log[base & 63]), 64'(base_l + 5));

      // R3: a gap restarts the run
      cfg_write(7, 1'b0, 1'b1);
      base = log_total;
      base_l = AW'(13 * 64);
      rd(base_l, h, d, f, fl);
      rd(base_l + 2, h, d, f, fl);
      idle(4);
      chk(log_total == base, "R3 gap no lock", 64'(log_total - base), 0);
      cfg_write(7, 1'b0, 1'b0);

      // R10: fill and read of the same line in one cycle
      base_l = AW'(14 * 64 + 5);
      @(negedge clk);
      fill_valid = 1'b1; fill_line = base_l; fill_data = pat(base_l);
      rd_valid = 1'b1;   rd_line = base_l;
      @(negedge clk);
      chk(rsp_hit == 0 && fwd_valid == 1 && fwd_line == base_l, "R10 same-cycle miss",
          64'({rsp_hit, fwd_valid}), 64'b01);
      fill_valid = 1'b0; rd_valid = 1'b0;
      rd(base_l, h, d, f, fl);
      chk(h == 1 && d == pat(base_l), "R10 later hit", 64'(h), 1);

      // R2: setting the bit drops buffered lines
      cfg_write(7, 1'b0, 1'b1);
      rd(base_l, h, d, f, fl);
      chk(h == 0 && f == 1, "R2 buffer flushed", 64'({h, f}), 64'b01);
      cfg_write(7, 1'b0, 1'b0);

      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule